// File: doc/BRIEF.md
# In-Band Interrupt Queue Packer

This block gathers in-band interrupt events seen by a serial bus controller and turns each one into a framed record in a 32-bit wide queue that software drains one word at a time. While an event is in progress its payload bytes are collected in a small byte FIFO. When the event completes, the block decides whether to report it. It then writes one status word that describes the event. After that it writes the payload, with four bytes to each word.

The status word carries the requester address, the direction bit, a rejected flag, a length field and a slice count. The slice size is programmed in 32-bit units. The queue keeps a word count that is visible on the ports. It also raises a level-triggered threshold interrupt. A synchronous clear input empties all of the buffering.

Top module: `ibi_queue_packer`

## Requirements
- R1: A payload byte is accepted (byte_ready=1) only when the byte FIFO (16 entries) has room, no event is being packed (busy=0) and evt_done is low in that cycle. A refused byte is not stored.
- R2: After evt_done for a reported event, the first word written to the queue is the status word. Its layout is: [7:0] length, [15:8] slice count, [22:16] address, [23] direction, [30:24] zero, [31] rejected flag.
- R3: Payload byte number j (counting from 0 in arrival order) sits in bits [8*(j mod 4)+7 : 8*(j mod 4)] of payload word j/4. Payload words follow the status word in order.
- R4: If the byte count is not a multiple of four, the last partial word is still written, and its unused lanes read zero.
- R5: If the event is rejected (evt_rej=1) while notification is off (evt_notify=0), nothing is written to the queue and the collected bytes are discarded.
- R6: level equals the number of words held in the queue. It goes up by one on each write and down by one on each read of a non-empty queue.
- R7: thld_irq is set by a write that leaves level >= thr. It is cleared by a read that leaves level < thr.
- R8: The slice size in bytes is 4*slice_words. The length field holds the byte count, or the slice size if the byte count is larger. The slice count is the byte count divided by the slice size, rounded up.
- R9: While the queue is empty, rd_data reads zero, and a read leaves level at zero.
- R10: A q_clear pulse empties the byte FIFO and the word queue and clears thld_irq.
- R11: A rejected event with notification on (evt_notify=1) is reported with bit 31 of its status word set, and its payload is written after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | Payload byte offered |
| byte_data | input | 8 | Payload byte |
| byte_ready | output | 1 | Offered byte is taken this cycle |
| evt_done | input | 1 | Event complete, one-cycle pulse |
| evt_addr | input | 7 | Requester address |
| evt_rnw | input | 1 | Direction bit of the event |
| evt_rej | input | 1 | Event was rejected |
| evt_notify | input | 1 | Report rejected events |
| slice_words | input | 3 | Slice size in 32-bit units |
| thr | input | 5 | Word-count threshold |
| rd_en | input | 1 | Read (pop) the queue head |
| rd_data | output | 32 | Queue head, zero when empty |
| level | output | 5 | Words held in the queue |
| thld_irq | output | 1 | Threshold interrupt |
| busy | output | 1 | An event is being packed |
| q_clear | input | 1 | Empty all buffering |

## Verification
The hardest case to reach is the byte FIFO filling right up. The bench offers seventeen bytes back to back and watches byte_ready drop on the last one. It then completes the event with a slice smaller than the payload. This covers both the refusal and the case where the length is capped by the slice size, and it also exercises a long run of lane wraps. The discard path is proven indirectly. A rejected, silent event is followed by a zero-byte accepted event, which must produce exactly one status word and no stray payload.

// File: rtl/ibiq_pkg.sv
package ibiq_pkg;

  typedef enum logic [1:0] {PK_IDLE, PK_STATUS, PK_PACK} pk_state_e;

  // Build the event status word from the byte count and event attributes.
  function automatic logic [31:0] make_status(input logic [7:0] nbytes,
                                              input logic [2:0] slice_words,
                                              input logic [6:0] addr,
                                              input logic       rnw,
                                              input logic       rej);
    logic [7:0] sbytes;
    logic [7:0] len;
    logic [7:0] nsl;
    sbytes = (slice_words == 3'd0) ? 8'd4 : {3'b000, slice_words, 2'b00};
    len    = (nbytes > sbytes) ? sbytes : nbytes;
    nsl    = (nbytes + sbytes - 8'd1) / sbytes;
    return {rej, 7'd0, rnw, addr, nsl, len};
  endfunction

endpackage

// File: rtl/ibiq_fifo.sv
module ibiq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr, wptr_n, rptr_n;
  logic [CW-1:0] count_n;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rptr];

  always_comb begin
    wptr_n  = wptr;
    rptr_n  = rptr;
    count_n = count;
    if (clr) begin
      wptr_n  = '0;
      rptr_n  = '0;
      count_n = '0;
    end else begin
      if (do_push) wptr_n = wptr + AW'(1);
      if (do_pop)  rptr_n = rptr + AW'(1);
      count_n = count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= wptr_n;
      rptr  <= rptr_n;
      count <= count_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wptr] <= wdata;
  end

endmodule

// File: rtl/ibiq_packer.sv
module ibiq_packer
  import ibiq_pkg::*;
#(
  parameter int BCW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           q_clear,
  input  logic           evt_done,
  input  logic           evt_rej,
  input  logic           evt_notify,
  input  logic [31:0]    status_in,
  input  logic [BCW-1:0] bf_count,
  input  logic           bf_empty,
  input  logic [7:0]     bf_rdata,
  input  logic           wq_full,
  output logic           bf_pop,
  output logic           bf_drop,
  output logic           wq_push,
  output logic [31:0]    wq_wdata,
  output logic           busy
);

  pk_state_e   state, state_n;
  logic [1:0]  lane, lane_n;
  logic [31:0] acc, acc_n;
  logic [31:0] stat, stat_n;
  logic [31:0] merged;

  assign busy   = (state != PK_IDLE);
  assign merged = acc | ({24'd0, bf_rdata} << {lane, 3'b000});

  always_comb begin
    state_n  = state;
    lane_n   = lane;
    acc_n    = acc;
    stat_n   = stat;
    bf_pop   = 1'b0;
    bf_drop  = 1'b0;
    wq_push  = 1'b0;
    wq_wdata = '0;
    unique case (state)
      PK_IDLE: begin
        if (evt_done) begin
          if (evt_rej && !evt_notify) begin
            bf_drop = 1'b1;
          end else begin
            stat_n  = status_in;
            lane_n  = '0;
            acc_n   = '0;
            state_n = PK_STATUS;
          end
        end
      end
      PK_STATUS: begin
        if (!wq_full) begin
          wq_push  = 1'b1;
          wq_wdata = stat;
          state_n  = PK_PACK;
        end
      end
      PK_PACK: begin
        if (bf_empty) begin
          state_n = PK_IDLE;
        end else if (!wq_full) begin
          bf_pop = 1'b1;
          lane_n = lane + 2'd1;
          if (lane == 2'd3 || bf_count == BCW'(1)) begin
            wq_push  = 1'b1;
            wq_wdata = merged;
            acc_n    = '0;
          end else begin
            acc_n = merged;
          end
        end
      end
      default: state_n = PK_IDLE;
    endcase
    if (q_clear) begin
      state_n = PK_IDLE;
      bf_pop  = 1'b0;
      wq_push = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PK_IDLE;
      lane  <= '0;
      acc   <= '0;
      stat  <= '0;
    end else begin
      state <= state_n;
      lane  <= lane_n;
      acc   <= acc_n;
      stat  <= stat_n;
    end
  end

endmodule

// File: rtl/ibi_queue_packer.sv
module ibi_queue_packer
  import ibiq_pkg::*;
#(
  parameter int BYTE_DEPTH = 16,
  parameter int WORD_DEPTH = 16,
  localparam int BCW = $clog2(BYTE_DEPTH + 1),
  localparam int LCW = $clog2(WORD_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           byte_valid,
  input  logic [7:0]     byte_data,
  output logic           byte_ready,
  input  logic           evt_done,
  input  logic [6:0]     evt_addr,
  input  logic           evt_rnw,
  input  logic           evt_rej,
  input  logic           evt_notify,
  input  logic [2:0]     slice_words,
  input  logic [LCW-1:0] thr,
  input  logic           rd_en,
  output logic [31:0]    rd_data,
  output logic [LCW-1:0] level,
  output logic           thld_irq,
  output logic           busy,
  input  logic           q_clear
);

  logic [BCW-1:0] bf_count;
  logic           bf_full, bf_empty, bf_pop, bf_drop;
  logic [7:0]     bf_rdata;
  logic           wq_push, wq_full, wq_empty, wq_pop;
  logic [31:0]    wq_wdata, wq_rdata;
  logic [31:0]    status_in;
  logic [LCW-1:0] level_n;
  logic           irq_n;

  assign byte_ready = !bf_full && !busy && !evt_done;
  assign status_in  = make_status(8'(bf_count), slice_words, evt_addr, evt_rnw, evt_rej);

  ibiq_fifo #(.W(8), .DEPTH(BYTE_DEPTH)) byte_fifo_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (q_clear || bf_drop),
    .push  (byte_valid && byte_ready),
    .wdata (byte_data),
    .pop   (bf_pop),
    .rdata (bf_rdata),
    .count (bf_count),
    .full  (bf_full),
    .empty (bf_empty)
  );

  ibiq_packer #(.BCW(BCW)) packer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .q_clear    (q_clear),
    .evt_done   (evt_done),
    .evt_rej    (evt_rej),
    .evt_notify (evt_notify),
    .status_in  (status_in),
    .bf_count   (bf_count),
    .bf_empty   (bf_empty),
    .bf_rdata   (bf_rdata),
    .wq_full    (wq_full),
    .bf_pop     (bf_pop),
    .bf_drop    (bf_drop),
    .wq_push    (wq_push),
    .wq_wdata   (wq_wdata),
    .busy       (busy)
  );

  assign wq_pop = rd_en && !wq_empty && !q_clear;

  ibiq_fifo #(.W(32), .DEPTH(WORD_DEPTH)) word_fifo_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (q_clear),
    .push  (wq_push),
    .wdata (wq_wdata),
    .pop   (wq_pop),
    .rdata (wq_rdata),
    .count (level),
    .full  (wq_full),
    .empty (wq_empty)
  );

  assign rd_data = wq_empty ? 32'd0 : wq_rdata;

  // Threshold interrupt: set on a write, cleared on a read, judged on new level.
  always_comb begin
    level_n = level + LCW'(wq_push && !wq_full) - LCW'(wq_pop);
    irq_n   = thld_irq;
    if (q_clear) begin
      irq_n = 1'b0;
    end else if (wq_push && level_n >= thr) begin
      irq_n = 1'b1;
    end else if (wq_pop && level_n < thr) begin
      irq_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thld_irq <= 1'b0;
    else        thld_irq <= irq_n;
  end

endmodule

module ibiq_checker #(
  parameter int LCW   = 5,
  parameter int DEPTH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           q_clear,
  input logic           rd_en,
  input logic [LCW-1:0] level,
  input logic [LCW-1:0] thr,
  input logic           thld_irq,
  input logic           busy,
  input logic           byte_ready,
  input logic           evt_done,
  input logic           evt_rej,
  input logic           evt_notify
);

  // R6
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LCW'(DEPTH));

  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && level == '0 && !busy && !q_clear) |=> level == '0);

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thld_irq) |-> level >= $past(thr));

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_clear |=> (level == '0 && !thld_irq));

  // R1
  no_byte_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !byte_ready);

  // R5
  silent_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_done && evt_rej && !evt_notify && !busy) |=> !busy);

endmodule

bind ibi_queue_packer ibiq_checker #(.LCW(LCW), .DEPTH(WORD_DEPTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .q_clear    (q_clear),
  .rd_en      (rd_en),
  .level      (level),
  .thr        (thr),
  .thld_irq   (thld_irq),
  .busy       (busy),
  .byte_ready (byte_ready),
  .evt_done   (evt_done),
  .evt_rej    (evt_rej),
  .evt_notify (evt_notify)
);

// File: tb/ibi_queue_packer_tb.sv
module ibi_queue_packer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_valid;
  logic [7:0]  byte_data;
  logic        byte_ready;
  logic        evt_done;
  logic [6:0]  evt_addr;
  logic        evt_rnw;
  logic        evt_rej;
  logic        evt_notify;
  logic [2:0]  slice_words;
  logic [4:0]  thr;
  logic        rd_en;
  logic [31:0] rd_data;
  logic [4:0]  level;
  logic        thld_irq;
  logic        busy;
  logic        q_clear;

  int checks = 0;
  int errors = 0;
  logic [31:0] w;

  always #4 clk = ~clk;

  ibi_queue_packer dut_i (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .evt_done(evt_done), .evt_addr(evt_addr),
    .evt_rnw(evt_rnw), .evt_rej(evt_rej), .evt_notify(evt_notify),
    .slice_words(slice_words), .thr(thr), .rd_en(rd_en), .rd_data(rd_data),
    .level(level), .thld_irq(thld_irq), .busy(busy), .q_clear(q_clear)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    byte_valid = 1'b1;
    byte_data  = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic finish_evt(input logic [6:0] a, input logic rnw, input logic rej,
                            input logic notify, input logic [2:0] sw);
    evt_addr = a; evt_rnw = rnw; evt_rej = rej; evt_notify = notify; slice_words = sw;
    evt_done = 1'b1;
    @(negedge clk);
    evt_done = 1'b0;
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
  endtask

  task automatic read_word(output logic [31:0] d);
    d = rd_data;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic drain();
    logic [31:0] d;
    for (int i = 0; i < 20 && level != 0; i++) read_word(d);
  endtask

  task automatic t_reset();
    chk("R6 reset level", 32'(level), 32'd0);
    chk("R7 reset irq", 32'(thld_irq), 32'd0);
    chk("R9 reset rd_data", rd_data, 32'd0);
    chk("R1 reset ready", 32'(byte_ready), 32'd1);
  endtask

  task automatic t_partial();  // 6 bytes, slice 4 bytes, threshold 3
    thr = 5'd3;
    for (int i = 0; i < 6; i++) send_byte(8'h11 + 8'(i));
    finish_evt(7'h2A, 1'b1, 1'b0, 1'b0, 3'd1);
    chk("R6 level after 6 bytes", 32'(level), 32'd3);
    chk("R7 irq at threshold", 32'(thld_irq), 32'd1);
    read_word(w); chk("R2 R8 status word", w, 32'h00AA0204);
    chk("R7 irq cleared below thr", 32'(thld_irq), 32'd0);
    chk("R6 level after read", 32'(level), 32'd2);
    read_word(w); chk("R3 first payload", w, 32'h14131211);
    read_word(w); chk("R4 partial word", w, 32'h00001615);
    thr = 5'd31;
  endtask

  task automatic t_exact();
    thr = 5'd3;
    send_byte(8'hAA); send_byte(8'hBB); send_byte(8'hCC); send_byte(8'hDD);
    finish_evt(7'h05, 1'b0, 1'b0, 1'b0, 3'd2);
    chk("R7 irq stays low below thr", 32'(thld_irq), 32'd0);
    chk("R6 level exact", 32'(level), 32'd2);
    read_word(w); chk("R8 status short event", w, 32'h00050104);
    read_word(w); chk("R3 aligned payload", w, 32'hDDCCBBAA);
    thr = 5'd31;
  endtask

  task automatic t_silent_reject();
    send_byte(8'h77); send_byte(8'h78);
    finish_evt(7'h40, 1'b1, 1'b1, 1'b0, 3'd1);
    @(negedge clk);
    chk("R5 nothing pushed", 32'(level), 32'd0);
    finish_evt(7'h10, 1'b0, 1'b0, 1'b0, 3'd1);
    chk("R5 bytes discarded", 32'(level), 32'd1);
    read_word(w); chk("R8 zero-byte status", w, 32'h00100000);
  endtask

  task automatic t_notify_reject();
    send_byte(8'h5A);
    finish_evt(7'h33, 1'b1, 1'b1, 1'b1, 3'd1);
    chk("R11 reported level", 32'(level), 32'd2);
    read_word(w); chk("R11 rejected status", w, 32'h80B30101);
    read_word(w); chk("R11 R4 payload", w, 32'h0000005A);
  endtask

  task automatic t_full();
    for (int i = 0; i < 16; i++) send_byte(8'(i));
    chk("R1 refused when full", 32'(byte_ready), 32'd0);
    send_byte(8'hEE);
    finish_evt(7'h01, 1'b0, 1'b0, 1'b0, 3'd3);
    chk("R1 R6 level full event", 32'(level), 32'd5);
    read_word(w); chk("R8 capped length", w, 32'h0001020C);
    read_word(w); chk("R3 word0", w, 32'h03020100);
    read_word(w); read_word(w);
    read_word(w); chk("R1 last word no extra", w, 32'h0F0E0D0C);
    chk("R6 drained", 32'(level), 32'd0);
  endtask

  task automatic t_empty_read();
    chk("R9 empty rd_data", rd_data, 32'd0);
    read_word(w);
    chk("R9 level after empty read", 32'(level), 32'd0);
  endtask

  task automatic t_clear();
    thr = 5'd2;
    for (int i = 0; i < 6; i++) send_byte(8'(i));
    finish_evt(7'h02, 1'b0, 1'b0, 1'b0, 3'd1);
    chk("R7 irq before clear", 32'(thld_irq), 32'd1);
    send_byte(8'h99);
    q_clear = 1'b1;
    @(negedge clk);
    q_clear = 1'b0;
    chk("R10 level cleared", 32'(level), 32'd0);
    chk("R10 irq cleared", 32'(thld_irq), 32'd0);
    finish_evt(7'h03, 1'b0, 1'b0, 1'b0, 3'd1);
    chk("R10 byte fifo emptied", 32'(level), 32'd1);
    read_word(w); chk("R10 status after clear", w, 32'h00030000);
    thr = 5'd31;
  endtask

  initial begin
    rst_n = 1'b0; byte_valid = 1'b0; byte_data = '0; evt_done = 1'b0;
    evt_addr = '0; evt_rnw = 1'b0; evt_rej = 1'b0; evt_notify = 1'b0;
    slice_words = 3'd1; thr = 5'd31; rd_en = 1'b0; q_clear = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_partial();       drain();
    t_exact();         drain();
    t_silent_reject(); drain();
    t_notify_reject(); drain();
    t_full();          drain();
    t_empty_read();
    t_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule